// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Target

This block models the target side of a three-wire serial EEPROM: a chip select, a shift clock and a data-in line arrive from a host, and the block drives a data-out line with an output enable. All three inputs are brought through two-flop synchronisers into a fast system clock, and their edges are found there. Each transaction opens on a rising chip select. The host then sends a start bit, a two-bit opcode and an address, followed by data for the instructions that need it. Storage is a 512-byte register array. A strap input decides whether the array is seen as 512 eight-bit words or 256 sixteen-bit words.

Writes, erases and the two bulk operations go through a programming-enable latch, which is clear after reset. Each of them starts a self-timed programming cycle with a parameterised length in system clocks. While that cycle runs, the host can drop chip select and raise it again to watch the ready/busy level on data out. Reads send one leading zero bit and then stream words MSB first. While chip select stays high, the address advances after each word with no gap.

The controller is a single state machine with these states:
- ST_IDLE waits for a chip-select rise. It moves to ST_STATUS if a program cycle is running, and to ST_START otherwise.
- ST_START skips zeros and moves to ST_OPC on the start bit.
- ST_OPC takes two opcode bits, then moves to ST_ADDR.
- ST_ADDR takes the address field and then dispatches:
  - a read goes to ST_READ;
  - a write and write-all go to ST_DATA;
  - erase, erase-all, enable and disable go straight to ST_DONE.
- ST_DATA takes the data word, then moves to ST_DONE.
- ST_READ streams words out.
- ST_DONE ignores further bits.
- ST_STATUS shows ready/busy.

A chip-select fall sends every state back to ST_IDLE.

Top module: `sereep_slave`

## Requirements
- R1: After reset, data out is 0 with output enable low, the programming-enable latch is clear, and every array byte reads as 8'hFF.
- R2: An instruction is framed by a chip-select rise and sampled on shift-clock rising edges. Zeros before the start bit (a 1) are skipped. The start bit is followed by a 2-bit opcode and then an address, MSB first: 9 bits when the strap is low (8-bit words), 8 bits when the strap is high (16-bit words).
- R3: Opcode 10 (read). On the rising edge that carries the last address bit, data out goes to a dummy 0 with output enable high. Each later rising edge presents the next bit of the addressed word, MSB first.
- R4: While chip select stays high, a read continues with the next address and no dummy bit. The address wraps from the last word (511, or 255 in 16-bit mode) to 0.
- R5: Opcode 01 (write) takes a data word of 8 or 16 bits, MSB first, and stores it. In 16-bit mode, word a holds bytes 2a (the high byte) and 2a+1 (the low byte). An 8-bit-mode read of those bytes therefore returns the high byte, then the low byte.
- R6: Opcode 11 (erase) sets every bit of the addressed word to 1.
- R7: Opcode 00 selects an extended instruction from the top two address bits:
  - 11 enables programming;
  - 00 disables programming;
  - 10 sets every byte to 8'hFF;
  - 01 is followed by a data word that is written to every location.
- R8: While the programming-enable latch is clear, write, erase, erase-all and write-all leave the array unchanged.
- R9: Each accepted write, erase or bulk operation starts a program cycle of PROG_CYCLES system clocks. If chip select goes low and then high during that cycle, output enable goes high. Data out then shows 0 while busy and 1 once ready, until chip select falls.
- R10: If chip select rises after the program cycle has ended, no status is shown: output enable stays low.
- R11: An instruction whose chip-select rise arrives during a program cycle is ignored, even if the cycle ends before the bits finish.
- R12: A chip-select fall aborts any instruction in progress without changing the array. Output enable is low within three system clocks of chip select going low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the shift clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Chip select from the host, asynchronous |
| sclk_i | input | 1 | Shift clock from the host, asynchronous |
| sdi_i | input | 1 | Serial data in from the host |
| wide_org_i | input | 1 | Organisation strap: 1 selects 16-bit words, 0 selects 8-bit words |
| sdo_o | output | 1 | Serial data out: read bits or ready/busy level |
| sdo_oe_o | output | 1 | Output enable for data out; low means released |

## Verification
Reads are tried in both organisations, across a word boundary and across the top-of-array wrap. Byte-mode reads of a word written in 16-bit mode show whether the two halves land in the right byte order. Writes are sent before and after the enable instruction, after disable, cut short by a chip-select fall, and issued during a running program cycle. This separates the effect of the enable latch, the abort path and the busy lockout. Status is sampled with chip select re-raised early and late in a program cycle, and raised only after it ends, so that busy, ready and no-status are each seen on data out.

// File: rtl/sereep_pkg.sv
package sereep_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_OPC,
        ST_ADDR,
        ST_DATA,
        ST_READ,
        ST_DONE,
        ST_STATUS
    } state_t;

    typedef enum logic [2:0] {
        MOP_NONE,
        MOP_WRITE,
        MOP_ERASE,
        MOP_ERASE_ALL,
        MOP_WRITE_ALL
    } mop_t;

    localparam logic [1:0] OPC_EXT   = 2'b00;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_ERASE = 2'b11;

    localparam logic [1:0] EXT_DISABLE   = 2'b00;
    localparam logic [1:0] EXT_WRITE_ALL = 2'b01;
    localparam logic [1:0] EXT_ERASE_ALL = 2'b10;
    localparam logic [1:0] EXT_ENABLE    = 2'b11;

endpackage

// File: rtl/sereep_sync.sv
module sereep_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_raw,
    input  logic sclk_raw,
    input  logic sdi_raw,
    output logic sdi_q,
    output logic sk_rise,
    output logic cs_rise,
    output logic cs_fall
);
    localparam int NSIG = 3;
    localparam int DEPTH = STAGES + 1;

    logic [NSIG-1:0] raw;
    logic [NSIG-1:0] chain [DEPTH];

    assign raw = {sel_raw, sclk_raw, sdi_raw};

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[g] <= '0;
                end else begin
                    if (g == 0) begin
                        chain[g] <= raw;
                    end else begin
                        chain[g] <= chain[(g > 0) ? g - 1 : 0];
                    end
                end
            end
        end
    endgenerate

    assign sdi_q   = chain[STAGES-1][0];
    assign sk_rise = chain[STAGES-1][1] & ~chain[STAGES][1];
    assign cs_rise = chain[STAGES-1][2] & ~chain[STAGES][2];
    assign cs_fall = ~chain[STAGES-1][2] & chain[STAGES][2];

endmodule

// File: rtl/sereep_timer.sv
module sereep_timer #(
    parameter int CYCLES = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CNTW = $clog2(CYCLES + 1);

    logic [CNTW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CNTW'(CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);

    assert_start_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNTW'(CYCLES));

    assert_cnt_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sereep_array.sv
module sereep_array
    import sereep_pkg::*;
#(
    parameter int ABITS = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  mop_t             op,
    input  logic             wide,
    input  logic [ABITS-1:0] addr,
    input  logic [15:0]      wdata,
    input  logic [ABITS-1:0] rd_addr,
    output logic [15:0]      rd_word
);
    localparam int DEPTH = 1 << ABITS;

    logic [7:0] mem [DEPTH];

    logic [ABITS-1:0] w_hi, w_lo, r_hi, r_lo;

    assign w_hi = wide ? {addr[ABITS-2:0], 1'b0} : addr;
    assign w_lo = {addr[ABITS-2:0], 1'b1};
    assign r_hi = wide ? {rd_addr[ABITS-2:0], 1'b0} : rd_addr;
    assign r_lo = {rd_addr[ABITS-2:0], 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= 8'hFF;
            end
        end else begin
            unique case (op)
                MOP_WRITE: begin
                    if (wide) begin
                        mem[w_hi] <= wdata[15:8];
                        mem[w_lo] <= wdata[7:0];
                    end else begin
                        mem[w_hi] <= wdata[7:0];
                    end
                end
                MOP_ERASE: begin
                    mem[w_hi] <= 8'hFF;
                    if (wide) begin
                        mem[w_lo] <= 8'hFF;
                    end
                end
                MOP_ERASE_ALL: begin
                    for (int i = 0; i < DEPTH; i++) begin
                        mem[i] <= 8'hFF;
                    end
                end
                MOP_WRITE_ALL: begin
                    for (int i = 0; i < DEPTH; i++) begin
                        if (wide && ((i % 2) == 0)) begin
                            mem[i] <= wdata[15:8];
                        end else begin
                            mem[i] <= wdata[7:0];
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign rd_word = wide ? {mem[r_hi], mem[r_lo]} : {mem[r_hi], 8'h00};

endmodule

// File: rtl/sereep_slave.sv
module sereep_slave
    import sereep_pkg::*;
#(
    parameter int BYTE_ABITS  = 9,
    parameter int PROG_CYCLES = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_i,
    input  logic sclk_i,
    input  logic sdi_i,
    input  logic wide_org_i,
    output logic sdo_o,
    output logic sdo_oe_o
);
    localparam int CW = 5;

    state_t state_q, state_d;
    mop_t   mem_op;
    logic   tmr_start, busy;
    logic   di, sk_rise, cs_rise, cs_fall;

    logic [CW-1:0]         cnt_q;
    logic [1:0]            opc_q;
    logic [BYTE_ABITS-1:0] addr_q, addr_next, mem_addr;
    logic [14:0]           data_q;
    logic [15:0]           data_next, shreg_q, rd_word, rd_pick;
    logic                  sdo_q, prog_en_q;
    logic [1:0]            ext_code;
    logic [CW-1:0]         abits_m1, dbits_m1;

    sereep_sync #(.STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_raw  (sel_i),
        .sclk_raw (sclk_i),
        .sdi_raw  (sdi_i),
        .sdi_q    (di),
        .sk_rise  (sk_rise),
        .cs_rise  (cs_rise),
        .cs_fall  (cs_fall)
    );

    sereep_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .busy  (busy)
    );

    assign mem_addr = (state_q == ST_ADDR) ? addr_next : addr_q;

    sereep_array #(.ABITS(BYTE_ABITS)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (mem_op),
        .wide    (wide_org_i),
        .addr    (mem_addr),
        .wdata   (data_next),
        .rd_addr (addr_q),
        .rd_word (rd_word)
    );

    assign addr_next = {addr_q[BYTE_ABITS-2:0], di};
    assign data_next = {data_q, di};
    assign abits_m1  = wide_org_i ? CW'(BYTE_ABITS - 2) : CW'(BYTE_ABITS - 1);
    assign dbits_m1  = wide_org_i ? CW'(15) : CW'(7);
    assign ext_code  = wide_org_i ? addr_next[BYTE_ABITS-2 -: 2]
                                  : addr_next[BYTE_ABITS-1 -: 2];
    assign rd_pick   = (cnt_q == '0) ? rd_word : shreg_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and array/timer commands
    always_comb begin
        state_d   = state_q;
        mem_op    = MOP_NONE;
        tmr_start = 1'b0;
        if (cs_fall) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cs_rise) begin
                        state_d = busy ? ST_STATUS : ST_START;
                    end
                end
                ST_START: begin
                    if (sk_rise && di) begin
                        state_d = ST_OPC;
                    end
                end
                ST_OPC: begin
                    if (sk_rise && cnt_q == CW'(1)) begin
                        state_d = ST_ADDR;
                    end
                end
                ST_ADDR: begin
                    if (sk_rise && cnt_q == abits_m1) begin
                        unique case (opc_q)
                            OPC_READ:  state_d = ST_READ;
                            OPC_WRITE: state_d = ST_DATA;
                            OPC_ERASE: begin
                                state_d = ST_DONE;
                                if (prog_en_q) begin
                                    mem_op    = MOP_ERASE;
                                    tmr_start = 1'b1;
                                end
                            end
                            default: begin
                                if (ext_code == EXT_WRITE_ALL) begin
                                    state_d = ST_DATA;
                                end else begin
                                    state_d = ST_DONE;
                                    if (ext_code == EXT_ERASE_ALL && prog_en_q) begin
                                        mem_op    = MOP_ERASE_ALL;
                                        tmr_start = 1'b1;
                                    end
                                end
                            end
                        endcase
                    end
                end
                ST_DATA: begin
                    if (sk_rise && cnt_q == dbits_m1) begin
                        state_d = ST_DONE;
                        if (prog_en_q) begin
                            mem_op    = (opc_q == OPC_WRITE) ? MOP_WRITE : MOP_WRITE_ALL;
                            tmr_start = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            opc_q     <= '0;
            addr_q    <= '0;
            data_q    <= '0;
            shreg_q   <= '0;
            sdo_q     <= 1'b0;
            prog_en_q <= 1'b0;
        end else begin
            if (state_d == ST_STATUS) begin
                sdo_q <= ~busy;
            end
            if (cs_fall) begin
                cnt_q <= '0;
                sdo_q <= 1'b0;
            end else if (sk_rise) begin
                unique case (state_q)
                    ST_START: begin
                        if (di) begin
                            cnt_q  <= '0;
                            opc_q  <= '0;
                            addr_q <= '0;
                        end
                    end
                    ST_OPC: begin
                        opc_q <= {opc_q[0], di};
                        cnt_q <= (cnt_q == CW'(1)) ? '0 : cnt_q + 1'b1;
                    end
                    ST_ADDR: begin
                        addr_q <= addr_next;
                        if (cnt_q == abits_m1) begin
                            cnt_q  <= '0;
                            data_q <= '0;
                            sdo_q  <= 1'b0;
                            if (opc_q == OPC_EXT && ext_code == EXT_ENABLE) begin
                                prog_en_q <= 1'b1;
                            end
                            if (opc_q == OPC_EXT && ext_code == EXT_DISABLE) begin
                                prog_en_q <= 1'b0;
                            end
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        data_q <= data_next[14:0];
                        cnt_q  <= cnt_q + 1'b1;
                    end
                    ST_READ: begin
                        sdo_q   <= rd_pick[15];
                        shreg_q <= {rd_pick[14:0], 1'b0};
                        if (cnt_q == dbits_m1) begin
                            cnt_q  <= '0;
                            addr_q <= addr_q + 1'b1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        sdo_o    = sdo_q;
        sdo_oe_o = (state_q == ST_READ) || (state_q == ST_STATUS);
    end

    assert_oe_drop_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> !sdo_oe_o);

    assert_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_op != MOP_NONE) |-> prog_en_q);

    assert_no_op_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_op != MOP_NONE) |-> !busy);

    assert_status_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && busy) |=> (sdo_oe_o && !sdo_o));

    assert_no_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cs_rise && !busy) |=> !sdo_oe_o);

    assert_dummy_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ && $past(state_q) != ST_READ) |-> !sdo_o);

endmodule

// File: tb/sereep_slave_test.sv
module sereep_slave_test;
    localparam int PROG = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0, wide = 1'b0;
    logic sdo, oe;
    logic last_o, last_e;

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0] mm [512];
    bit en_m = 1'b0;

    always #5 clk = ~clk;

    sereep_slave #(.BYTE_ABITS(9), .PROG_CYCLES(PROG)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_i      (cs),
        .sclk_i     (sk),
        .sdi_i      (di),
        .wide_org_i (wide),
        .sdo_o      (sdo),
        .sdo_oe_o   (oe)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clks(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sel(bit v);
        @(negedge clk);
        cs = v;
        sk = 1'b0;
        clks(8);
    endtask

    task automatic clk_bit(bit b);
        @(negedge clk);
        di = b;
        sk = 1'b0;
        clks(8);
        sk = 1'b1;
        clks(8);
        last_o = sdo;
        last_e = oe;
    endtask

    task automatic send(logic [31:0] v, int n);
        for (int i = n - 1; i >= 0; i--) begin
            clk_bit(v[i]);
        end
    endtask

    function automatic int abits();
        return wide ? 8 : 9;
    endfunction

    function automatic int dbits();
        return wide ? 16 : 8;
    endfunction

    function automatic logic [15:0] mword(int a);
        if (wide) return {mm[(2 * a) % 512], mm[(2 * a + 1) % 512]};
        return {8'h00, mm[a % 512]};
    endfunction

    task automatic m_store(int a, logic [15:0] d);
        if (!en_m) return;
        if (wide) begin
            mm[2 * a] = d[15:8];
            mm[2 * a + 1] = d[7:0];
        end else begin
            mm[a] = d[7:0];
        end
    endtask

    task automatic do_write(int a, logic [15:0] d, int lead, bit wait_done);
        sel(1'b1);
        if (lead > 0) send(0, lead);
        send(3'b101, 3);
        send(a, abits());
        send(d, dbits());
        sel(1'b0);
        m_store(a, d);
        if (wait_done) clks(PROG + 20);
    endtask

    task automatic do_erase(int a);
        sel(1'b1);
        send(3'b111, 3);
        send(a, abits());
        sel(1'b0);
        m_store(a, 16'hFFFF);
        clks(PROG + 20);
    endtask

    task automatic do_ext(logic [1:0] code, logic [15:0] d);
        sel(1'b1);
        send(3'b100, 3);
        send({code, 7'b0} >> (9 - abits()), abits());
        if (code == 2'b01) send(d, dbits());
        sel(1'b0);
        if (code == 2'b11) en_m = 1'b1;
        if (code == 2'b00) en_m = 1'b0;
        if (en_m && code == 2'b10) for (int i = 0; i < 512; i++) mm[i] = 8'hFF;
        if (en_m && code == 2'b01)
            for (int i = 0; i < 512; i++) mm[i] = (wide && (i % 2 == 0)) ? d[15:8] : d[7:0];
        clks(PROG + 20);
    endtask

    task automatic do_read(int a, int n, string req);
        logic [15:0] exp;
        int sz;
        sz = wide ? 256 : 512;
        sel(1'b1);
        send(3'b110, 3);
        send(a >> 1, abits() - 1);
        clk_bit(a[0]);
        chk({req, " R3 dummy bit"}, last_o, 1'b0);
        chk({req, " R3 oe on dummy"}, last_e, 1'b1);
        for (int w = 0; w < n; w++) begin
            exp = mword((a + w) % sz);
            for (int b = dbits() - 1; b >= 0; b--) begin
                clk_bit(1'b0);
                chk($sformatf("%s R4 word %0d bit %0d", req, w, b), last_o, exp[b]);
            end
        end
        sel(1'b0);
        chk({req, " R12 oe low after deselect"}, oe, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 512; i++) mm[i] = 8'hFF;
        clks(5);
        rst_n = 1'b1;
        clks(3);
        chk("R1 reset oe", oe, 1'b0);
        chk("R1 reset sdo", sdo, 1'b0);

        // byte organisation
        wide = 1'b0;
        do_read(5, 1, "R1 erased array");
        do_write(5, 16'h003C, 0, 1'b1);
        do_read(5, 1, "R8 write before enable");

        do_ext(2'b11, 16'h0);
        do_write(5, 16'h003C, 0, 1'b1);
        do_write(6, 16'h00A5, 0, 1'b1);
        do_write(7, 16'h0081, 2, 1'b1);
        do_read(5, 3, "R5 R2 byte write and lead zeros");

        // word organisation and byte mapping
        wide = 1'b1;
        do_write(3, 16'h1234, 0, 1'b1);
        do_read(3, 1, "R5 word write");
        wide = 1'b0;
        do_read(6, 2, "R5 word byte order");

        do_erase(6);
        do_read(6, 1, "R6 erase");

        do_write(511, 16'h005A, 0, 1'b1);
        do_write(0, 16'h0066, 0, 1'b1);
        do_read(511, 2, "R4 byte wrap");

        // status while busy, then ready
        do_write(10, 16'h0077, 0, 1'b0);
        sel(1'b1);
        chk("R9 status oe while busy", oe, 1'b1);
        chk("R9 status busy level", sdo, 1'b0);
        clks(PROG + 20);
        chk("R9 status ready level", sdo, 1'b1);
        chk("R9 status oe when ready", oe, 1'b1);
        sel(1'b0);
        do_read(10, 1, "R9 data after program");

        // instruction during busy ignored
        do_write(11, 16'h0011, 0, 1'b0);
        sel(1'b1);
        send(3'b101, 3);
        send(11, 9);
        send(16'h0022, 8);
        sel(1'b0);
        clks(PROG + 20);
        do_read(11, 1, "R11 busy lockout");

        // late chip select shows no status
        do_write(12, 16'h0044, 0, 1'b0);
        clks(PROG + 40);
        sel(1'b1);
        chk("R10 no status after cycle", oe, 1'b0);
        sel(1'b0);

        // abort mid-instruction
        sel(1'b1);
        send(3'b101, 3);
        send(13, 9);
        send(4'hA, 4);
        sel(1'b0);
        chk("R12 oe after abort", oe, 1'b0);
        clks(PROG + 20);
        do_read(13, 1, "R12 aborted write");

        // disable then write
        do_ext(2'b00, 16'h0);
        do_write(14, 16'h0055, 0, 1'b1);
        do_read(14, 1, "R7 R8 write after disable");
        do_ext(2'b11, 16'h0);

        // bulk operations
        wide = 1'b1;
        do_ext(2'b01, 16'hBEEF);
        do_read(255, 2, "R7 write all and word wrap");
        wide = 1'b0;
        do_read(200, 2, "R7 write all byte view");
        do_ext(2'b10, 16'h0);
        do_read(100, 2, "R7 erase all");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule